// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

A 32-pin general-purpose I/O port behind a simple single-cycle register port. Software drives output values and output enables, reads the synchronized pin levels, and sets up each pin as an interrupt source. The interrupt type of a pin can be rising edge, falling edge, high level or low level. Each register can be written in three ways: a plain write, a write that sets only the bits written as one, and a write that clears only the bits written as one.

Each pin input passes through a two-flop synchronizer. The detector compares the synchronized value with its value one cycle earlier to find edges, or reads it directly for level detection. A detected event on a routed pin sets a sticky status bit. The port interrupt is raised while any status bit whose enable bit is set is one. When split mode is selected, the interrupt is carried on two outputs: one for the lower half of the pins and one for the upper half.

Top module: `gpio_irq_port`

## Requirements
- R1: Register selection uses addr_i[7:4]: 0 data-out, 1 data-in, 2 output-enable, 3 route, 4 enable, 5 level, 6 polarity, 7 status. With addr_i[3:2]=0, a write replaces the whole register. A read at any of the three aliases of an index returns that register, and indices 8 to 15 read as zero.
- R2: With addr_i[3:2]=1 (offset +0x4), a write sets the bits written as one. With addr_i[3:2]=2 (offset +0x8), a write clears the bits written as one. Bits written as zero keep their value in both cases.
- R3: The data-in register returns the pin inputs two clock edges after they change, and writes to it have no effect.
- R4: A pin's interrupt type comes from its level bit L and polarity bit P: L=0,P=0 falling edge; L=1,P=0 low level; L=0,P=1 rising edge; L=1,P=1 high level.
- R5: A detected event on a routed pin sets its status bit, and the bit reads back after the third clock edge following the input change.
- R6: A status bit stays set until software clears it, through the clear alias or a plain write.
- R7: A pin whose route bit is zero never sets its status bit.
- R8: An interrupt output is high only for status bits whose enable bit is one. Clearing an enable bit drops the interrupt but leaves the status bit and the route bit unchanged.
- R9: With irq_split_i=0, irq_o covers all pins and irq_hi_o stays low. With irq_split_i=1, irq_o covers pins 0-15 and irq_hi_o covers pins 16-31.
- R10: While a level-type pin stays at its active level, its status bit is set again on every cycle. A clear that lands in the same cycle as a detection event loses to the event.
- R11: After reset, every register is zero and both interrupt outputs are low.
- R12: dout_o and oe_o carry the data-out and output-enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Byte address: register index in [7:4], write form in [3:2] |
| we_i | input | 1 | Write strobe, taken on the rising clock edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| pins_i | input | 32 | Asynchronous pin levels |
| dout_o | output | 32 | Output values to the pads |
| oe_o | output | 32 | Output enables to the pads |
| irq_split_i | input | 1 | Selects split interrupt mode |
| irq_o | output | 1 | Port interrupt, or lower-half interrupt in split mode |
| irq_hi_o | output | 1 | Upper-half interrupt in split mode |

## Verification
The bench drives a rising edge on a falling-edge pin and checks that no status bit appears. A design that decodes the polarity bit the wrong way round would latch the wrong edge. A clear is written while a high-level pin is still active, and the status must read back as set; a design that lets the clear win would drop a pending level interrupt. Unrouted pins and masked pins are checked separately. A design that merged the two gates would either raise status without routing, or lose the status when the pin is masked. The bench also flips split mode with an upper-half pin pending, which catches an interrupt routed to the wrong output.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;
  localparam int unsigned REG_COUNT = 8;

  typedef enum logic [3:0] {
    RIX_DOUT  = 4'd0,
    RIX_DIN   = 4'd1,
    RIX_OE    = 4'd2,
    RIX_ROUTE = 4'd3,
    RIX_IEN   = 4'd4,
    RIX_LVL   = 4'd5,
    RIX_POL   = 4'd6,
    RIX_STAT  = 4'd7
  } reg_ix_e;

  typedef enum logic [1:0] {
    WOP_DIRECT = 2'd0,
    WOP_SET    = 2'd1,
    WOP_CLR    = 2'd2,
    WOP_NONE   = 2'd3
  } wop_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_alias_reg.sv
`timescale 1ns/1ps
module gpio_alias_reg
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  wop_e         op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hw_set_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_q, nxt;

  always_comb begin
    nxt = q_q;
    if (wr_i) begin
      unique case (op_i)
        WOP_DIRECT: nxt = wdata_i;
        WOP_SET:    nxt = q_q | wdata_i;
        WOP_CLR:    nxt = q_q & ~wdata_i;
        default:    nxt = q_q;
      endcase
    end
    // hardware set wins over any software clear
    nxt = nxt | hw_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_q <= '0;
    else         q_q <= nxt;
  end

  assign q_o = q_q;
endmodule

// File: rtl/gpio_event_detect.sv
`timescale 1ns/1ps
module gpio_event_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] sync_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] route_i,
  output logic [W-1:0] evt_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sync_i;
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    logic hit;
    always_comb begin
      if (lvl_i[p])      hit = (sync_i[p] == pol_i[p]);
      else if (pol_i[p]) hit = sync_i[p] & ~prev_q[p];
      else               hit = ~sync_i[p] & prev_q[p];
    end
    assign evt_o[p] = route_i[p] & hit;
  end
endmodule

// File: rtl/gpio_irq_port.sv
`timescale 1ns/1ps
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             we_i,
  input  logic [NPINS-1:0] wdata_i,
  output logic [NPINS-1:0] rdata_o,
  input  logic [NPINS-1:0] pins_i,
  output logic [NPINS-1:0] dout_o,
  output logic [NPINS-1:0] oe_o,
  input  logic             irq_split_i,
  output logic             irq_o,
  output logic             irq_hi_o
);
  localparam int unsigned HALF = NPINS / 2;
  localparam int unsigned IXW  = AW - 4;
  localparam int unsigned RIXW = $clog2(REG_COUNT);

  logic [IXW-1:0]   ix;
  wop_e             wop;
  logic [NPINS-1:0] regs [REG_COUNT];
  logic [NPINS-1:0] din_q, evt;
  logic [NPINS-1:0] route_q, ien_q, lvl_q, pol_q, stat_q, pend;

  assign ix  = addr_i[AW-1:4];
  assign wop = wop_e'(addr_i[3:2]);

  gpio_sync #(.W(NPINS), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (din_q)
  );

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    if (g == int'(RIX_DIN)) begin : g_ro
      assign regs[g] = din_q;
    end else begin : g_rw
      logic [NPINS-1:0] hw_set;
      if (g == int'(RIX_STAT)) begin : g_hs
        assign hw_set = evt;
      end else begin : g_nohs
        assign hw_set = '0;
      end
      gpio_alias_reg #(.W(NPINS)) u_reg (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (we_i && (ix == IXW'(g))),
        .op_i    (wop),
        .wdata_i (wdata_i),
        .hw_set_i(hw_set),
        .q_o     (regs[g])
      );
    end
  end

  assign dout_o  = regs[RIX_DOUT];
  assign oe_o    = regs[RIX_OE];
  assign route_q = regs[RIX_ROUTE];
  assign ien_q   = regs[RIX_IEN];
  assign lvl_q   = regs[RIX_LVL];
  assign pol_q   = regs[RIX_POL];
  assign stat_q  = regs[RIX_STAT];

  gpio_event_detect #(.W(NPINS)) u_det (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (din_q),
    .lvl_i  (lvl_q),
    .pol_i  (pol_q),
    .route_i(route_q),
    .evt_o  (evt)
  );

  assign rdata_o = (ix < IXW'(REG_COUNT)) ? regs[ix[RIXW-1:0]] : '0;

  assign pend     = stat_q & ien_q;
  assign irq_o    = irq_split_i ? |pend[HALF-1:0] : |pend;
  assign irq_hi_o = irq_split_i & |pend[NPINS-1:HALF];
endmodule

// File: rtl/gpio_irq_port_chk.sv
`timescale 1ns/1ps
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned AW    = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [AW-1:0]    addr_i,
  input logic             we_i,
  input logic [NPINS-1:0] wdata_i,
  input logic [NPINS-1:0] oe_o,
  input logic [NPINS-1:0] stat_q,
  input logic [NPINS-1:0] ien_q,
  input logic [NPINS-1:0] route_q,
  input logic             irq_split_i,
  input logic             irq_o,
  input logic             irq_hi_o
);
  logic oe_set, oe_clr, stat_wr;
  assign oe_set  = we_i && (addr_i[AW-1:4] == (AW-4)'(RIX_OE))   && (addr_i[3:2] == 2'(WOP_SET));
  assign oe_clr  = we_i && (addr_i[AW-1:4] == (AW-4)'(RIX_OE))   && (addr_i[3:2] == 2'(WOP_CLR));
  assign stat_wr = we_i && (addr_i[AW-1:4] == (AW-4)'(RIX_STAT));

  AST_SET_ALIAS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_set |=> ((oe_o & $past(wdata_i)) == $past(wdata_i)));  // R2
  AST_CLR_ALIAS_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_clr |=> ((oe_o & $past(wdata_i)) == '0));  // R2
  AST_ALIAS_KEEPS_ZEROS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oe_set || oe_clr) |=> ((oe_o & ~$past(wdata_i)) == ($past(oe_o) & ~$past(wdata_i))));  // R2
  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_wr |=> (($past(stat_q) & ~stat_q) == '0));  // R6
  AST_UNROUTED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stat_wr && route_q == '0 && stat_q == '0) |=> (stat_q == '0));  // R7
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || irq_hi_o) |-> (ien_q != '0));  // R8
  AST_HI_IDLE_MERGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_split_i |-> !irq_hi_o);  // R9
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .AW(AW)) u_chk (.*);

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  localparam logic [7:0] A_DOUT  = 8'h00;
  localparam logic [7:0] A_DIN   = 8'h10;
  localparam logic [7:0] A_OE    = 8'h20;
  localparam logic [7:0] A_ROUTE = 8'h30;
  localparam logic [7:0] A_IEN   = 8'h40;
  localparam logic [7:0] A_LVL   = 8'h50;
  localparam logic [7:0] A_POL   = 8'h60;
  localparam logic [7:0] A_STAT  = 8'h70;
  localparam logic [7:0] O_SET   = 8'h04;
  localparam logic [7:0] O_CLR   = 8'h08;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o, pins_i, dout_o, oe_o;
  logic        irq_split_i = 1'b0;
  logic        irq_o, irq_hi_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    int          kind;  // 0 rdata, 1 {irq_hi,irq}, 2 oe_o, 3 dout_o
    logic [31:0] exp;
    int          req;
  } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  gpio_irq_port dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pins_i(pins_i),
    .dout_o(dout_o), .oe_o(oe_o), .irq_split_i(irq_split_i),
    .irq_o(irq_o), .irq_hi_o(irq_hi_o)
  );

  // monitor: pops one expected item per cycle
  always @(negedge clk) begin
    if (sb_q.size() != 0) begin
      item_t it;
      logic [31:0] act;
      it = sb_q.pop_front();
      case (it.kind)
        0:       act = rdata_o;
        1:       act = {30'd0, irq_hi_o, irq_o};
        2:       act = oe_o;
        default: act = dout_o;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL R%0d kind=%0d actual=%08h expected=%08h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(input int kind, input logic [7:0] a, input logic [31:0] e, input int req);
    item_t it;
    @(posedge clk); #1;
    we_i = 1'b0;
    addr_i = a;
    it.kind = kind; it.exp = e; it.req = req;
    sb_q.push_back(it);
  endtask

  task automatic chk(input logic [7:0] a, input logic [31:0] e, input int req);
    push(0, a, e, req);
  endtask

  task automatic chk_irq(input logic [1:0] e, input int req);
    push(1, A_DOUT, {30'd0, e}, req);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr_i = a; wdata_i = d; we_i = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(posedge clk); #1;
      we_i = 1'b0;
    end
  endtask

  task automatic set_pins(input logic [31:0] v);
    @(posedge clk); #1;
    we_i = 1'b0;
    pins_i = v;
  endtask

  task automatic set_split(input logic s);
    @(posedge clk); #1;
    we_i = 1'b0;
    irq_split_i = s;
  endtask

  initial begin
    pins_i = '0;
    #12 rst_ni = 1'b1;
    // R11 reset state
    chk(A_DOUT, 32'h0, 11);
    chk(A_OE, 32'h0, 11);
    chk(A_STAT, 32'h0, 11);
    chk_irq(2'b00, 11);
    // R1 direct write and alias read
    wr(A_DOUT, 32'hA5A5_0F0F);
    chk(A_DOUT, 32'hA5A5_0F0F, 1);
    chk(8'h90, 32'h0, 1);
    // R2 set and clear aliases
    wr(A_DOUT | O_SET, 32'h0000_00F0);
    chk(A_DOUT, 32'hA5A5_0FFF, 2);
    wr(A_DOUT | O_CLR, 32'hA500_000F);
    chk(A_DOUT | O_SET, 32'h00A5_0FF0, 1);
    // R12 pad outputs
    wr(A_OE, 32'h0000_FFFF);
    wr(A_OE | O_SET, 32'h00FF_0000);
    push(2, A_DOUT, 32'h00FF_FFFF, 12);
    push(3, A_DOUT, 32'h00A5_0FF0, 12);
    // R3 data-in follows pins, writes ignored
    set_pins(32'h1234_5678);
    idle(2);
    chk(A_DIN, 32'h1234_5678, 3);
    wr(A_DIN, 32'hFFFF_FFFF);
    chk(A_DIN, 32'h1234_5678, 3);
    set_pins(32'h0);
    idle(3);
    wr(A_STAT | O_CLR, 32'hFFFF_FFFF);
    // R5 rising edge on pin 0
    wr(A_ROUTE | O_SET, 32'h1);
    wr(A_IEN | O_SET, 32'h1);
    wr(A_POL | O_SET, 32'h1);
    chk(A_STAT, 32'h0, 5);
    set_pins(32'h1);
    idle(2);
    chk(A_STAT, 32'h1, 5);
    chk_irq(2'b01, 8);
    // R6 sticky, then clear
    set_pins(32'h0);
    idle(3);
    chk(A_STAT, 32'h1, 6);
    wr(A_STAT | O_CLR, 32'h1);
    chk(A_STAT, 32'h0, 6);
    chk_irq(2'b00, 6);
    // R4 falling edge on pin 20 ignores rising edge
    wr(A_ROUTE | O_SET, 32'h0010_0000);
    wr(A_IEN | O_SET, 32'h0010_0000);
    set_pins(32'h0010_0000);
    idle(3);
    chk(A_STAT, 32'h0, 4);
    set_pins(32'h0);
    idle(3);
    chk(A_STAT, 32'h0010_0000, 4);
    // R9 merged vs split
    chk_irq(2'b01, 9);
    set_split(1'b1);
    chk_irq(2'b10, 9);
    // R8 mask keeps status and route
    wr(A_IEN | O_CLR, 32'h0010_0000);
    chk_irq(2'b00, 8);
    chk(A_STAT, 32'h0010_0000, 8);
    chk(A_ROUTE, 32'h0010_0001, 8);
    set_split(1'b0);
    wr(A_STAT | O_CLR, 32'hFFFF_FFFF);
    // R7 unrouted pin 8
    wr(A_IEN | O_SET, 32'h0000_0100);
    wr(A_POL | O_SET, 32'h0000_0100);
    set_pins(32'h0000_0100);
    idle(3);
    chk(A_STAT, 32'h0, 7);
    chk_irq(2'b00, 7);
    set_pins(32'h0);
    idle(3);
    // R10 high level on pin 4, set wins over clear
    wr(A_ROUTE | O_SET, 32'h10);
    wr(A_IEN | O_SET, 32'h10);
    wr(A_LVL | O_SET, 32'h10);
    wr(A_POL | O_SET, 32'h10);
    set_pins(32'h10);
    idle(3);
    chk(A_STAT, 32'h10, 10);
    wr(A_STAT | O_CLR, 32'h10);
    chk(A_STAT, 32'h10, 10);
    chk_irq(2'b01, 10);
    set_pins(32'h0);
    idle(3);
    wr(A_STAT | O_CLR, 32'h10);
    chk(A_STAT, 32'h0, 10);
    // R4 low level on pin 5 with pin already low
    wr(A_ROUTE | O_SET, 32'h20);
    wr(A_LVL | O_SET, 32'h20);
    idle(2);
    chk(A_STAT, 32'h20, 4);
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule